// File: doc/BRIEF.md
# Directory Coherence Controller (Write-Invalidate)

This block is the home-node directory of a small shared-memory system with a parameterised number of processors. For every memory block it stores one presence bit per processor and a dirty flag. The presence bits record which caches hold a copy. The dirty flag marks that the copy in main memory is stale because one cache holds a modified line. Processors send read or write requests through a valid/ready port. The directory serves them strictly one at a time, in the order they arrive.

A write that finds copies in other caches sends out one invalidate message. The message carries a mask of every other holder. The directory then waits until each targeted processor has acknowledged. Only then does it grant exclusive ownership. After that grant the writer is the only holder and the block is marked dirty. A read that finds the block modified in another cache first orders that owner to write the block back. When the write-back is done, the owner and the reader are both recorded as sharers and the block is clean again. Every other request is granted without any message. The caches and the network that carries the messages are outside this block.

Top module: `dircoh_directory`

## Requirements
- R1: After reset every block has an all-zero presence vector and a clear dirty flag, `reqReady` is 1, and `grantValid`, `invValid` and `fetchValid` are 0. The first write to any block is therefore granted with no invalidation.
- R2: Bit i of a presence vector and of `invMask` stands for processor i. `fetchOwner` is the binary index of the processor that holds the dirty copy. A dirty block always has exactly one presence bit set.
- R3: A write to a block that other processors hold produces exactly one single-cycle `invValid` pulse. Its `invMask` equals the current holders with the requester's bit cleared, and `invAddr` equals the block.
- R4: The write is granted only after every processor in `invMask` has pulsed its bit of `ackIn`. The grant comes two cycles after the cycle of the last such acknowledge. Acknowledges from processors that are not in the mask have no effect.
- R5: A write grant has `grantWrite`=1. Afterwards the block's presence vector holds only the writer and its dirty flag is set.
- R6: A read of a block that is dirty in another cache produces one `fetchValid` pulse that names the owner. The grant follows one cycle after the cycle in which `wbDone` is 1. Afterwards the owner and the reader both hold the block and it is clean.
- R7: A write from the only holder of a block, or to a block nobody holds, is granted two cycles after acceptance with no invalidation.
- R8: A read of a clean block, or a read by the owner of a dirty block, is granted two cycles after acceptance with no message. The reader is added to the holders and the dirty flag is left unchanged.
- R9: `reqReady` is 0 from the cycle after a request is accepted through the grant cycle, and is 1 again in the cycle after the grant. Requests are served one at a time in acceptance order.
- R10: `grantProc` and `grantAddr` repeat the processor index and block of the request being granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Directory can accept a request |
| reqWrite | input | 1 | 1 = write (exclusive) request, 0 = read |
| reqProc | input | PROC_W | Requesting processor index |
| reqAddr | input | ADDR_W | Block index |
| invValid | output | 1 | Invalidate message, one-cycle pulse |
| invMask | output | NUM_PROCS | Processors that must drop their copy |
| invAddr | output | ADDR_W | Block to invalidate |
| ackIn | input | NUM_PROCS | Per-processor invalidate acknowledge pulses |
| fetchValid | output | 1 | Write-back order to the owner, one-cycle pulse |
| fetchOwner | output | PROC_W | Owner that must write the block back |
| fetchAddr | output | ADDR_W | Block to write back |
| wbDone | input | 1 | Owner's write-back has reached memory |
| grantValid | output | 1 | Grant, one-cycle pulse |
| grantWrite | output | 1 | Grant is exclusive (write) |
| grantProc | output | PROC_W | Processor being granted |
| grantAddr | output | ADDR_W | Block being granted |

## Verification
The bench builds the block with four processors and eight blocks. With four processors, invalidate masks of one, two and three other holders can all be reached on a single block. The stray-acknowledge case of R4 always has a non-target processor to use. Eight blocks keep the directory small enough that untouched blocks, the last block index and blocks reused across many ownership changes all appear in one short run. The bench's own directory model predicts every message, owner index and grant cycle.

// File: rtl/dircoh_pkg.sv
package dircoh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_INV,
    ST_ACKWAIT,
    ST_FETCH,
    ST_WBWAIT,
    ST_GRANT
  } dirStateT;

  // control -> datapath strobes
  typedef struct packed {
    logic latchReq;
    logic loadPending;
    logic commit;
  } dirStrobeT;

  // datapath -> control status
  typedef struct packed {
    logic isWrite;
    logic othersAny;
    logic needFetch;
    logic pendingEmpty;
  } dirStatusT;

endpackage

// File: rtl/dircoh_datapath.sv
module dircoh_datapath
  import dircoh_pkg::*;
#(
  parameter int NUM_PROCS  = 8,
  parameter int NUM_BLOCKS = 64,
  localparam int PROC_W = $clog2(NUM_PROCS),
  localparam int ADDR_W = $clog2(NUM_BLOCKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dirStrobeT            strobe,
  output dirStatusT            status,
  input  logic                 reqWrite,
  input  logic [PROC_W-1:0]    reqProc,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [NUM_PROCS-1:0] ackIn,
  output logic [NUM_PROCS-1:0] othersMask,
  output logic [PROC_W-1:0]    ownerIdx,
  output logic                 curWrite,
  output logic [PROC_W-1:0]    curProc,
  output logic [ADDR_W-1:0]    curAddr
);

  logic [NUM_PROCS-1:0] presArr  [NUM_BLOCKS];
  logic                 dirtyArr [NUM_BLOCKS];
  logic [NUM_PROCS-1:0] pendingAcks;

  logic [NUM_PROCS-1:0] entryPres;
  logic                 entryDirty;
  logic [NUM_PROCS-1:0] reqMask;
  logic                 reqHolds;
  logic                 needFetch;

  // latched request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curWrite <= 1'b0;
      curProc  <= '0;
      curAddr  <= '0;
    end else if (strobe.latchReq) begin
      curWrite <= reqWrite;
      curProc  <= reqProc;
      curAddr  <= reqAddr;
    end
  end

  // directory lookup
  always_comb begin
    entryPres  = presArr[curAddr];
    entryDirty = dirtyArr[curAddr];
    reqMask    = '0;
    reqMask[curProc] = 1'b1;
    othersMask = entryPres & ~reqMask;
    reqHolds   = |(entryPres & reqMask);
    needFetch  = !curWrite && entryDirty && !reqHolds;
  end

  // owner index encoder (a dirty block has a single holder)
  always_comb begin
    ownerIdx = '0;
    for (int i = 0; i < NUM_PROCS; i++) begin
      if (entryPres[i]) ownerIdx = PROC_W'(i);
    end
  end

  // outstanding acknowledge mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingAcks <= '0;
    end else if (strobe.loadPending) begin
      pendingAcks <= othersMask;
    end else begin
      pendingAcks <= pendingAcks & ~ackIn;
    end
  end

  // directory storage and commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        presArr[b]  <= '0;
        dirtyArr[b] <= 1'b0;
      end
    end else if (strobe.commit) begin
      if (curWrite) begin
        presArr[curAddr]  <= reqMask;
        dirtyArr[curAddr] <= 1'b1;
      end else begin
        presArr[curAddr]  <= entryPres | reqMask;
        dirtyArr[curAddr] <= entryDirty & reqHolds;
      end
    end
  end

  always_comb begin
    status.isWrite      = curWrite;
    status.othersAny    = |othersMask;
    status.needFetch    = needFetch;
    status.pendingEmpty = (pendingAcks == '0);
  end

  // R2: a dirty block has exactly one holder
  p_dirty_single_owner_r2: assert property (@(posedge clk) disable iff (!rstN)
    entryDirty |-> $onehot(entryPres));

  // R4: no write grant while acknowledges are outstanding
  p_grant_needs_acks_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && curWrite) |-> (pendingAcks == '0));

  // R3: invalidations are only loaded for write requests
  p_inv_only_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPending |-> curWrite);

  // R5: a committed write leaves the writer alone and dirty
  p_write_commit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && curWrite) |=>
      (presArr[$past(curAddr)] == $past(reqMask)) && dirtyArr[$past(curAddr)]);

  // R6: a read that needed a write-back leaves the block clean, owner kept
  p_read_fetch_commit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && needFetch) |=>
      !dirtyArr[$past(curAddr)] && ((presArr[$past(curAddr)] & $past(entryPres)) != '0));

endmodule

// File: rtl/dircoh_control.sv
module dircoh_control
  import dircoh_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      wbDone,
  input  dirStatusT status,
  output dirStrobeT strobe,
  output logic      reqReady,
  output logic      invValid,
  output logic      fetchValid,
  output logic      grantValid
);

  dirStateT state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:    if (reqValid) nextState = ST_LOOKUP;
      ST_LOOKUP: begin
        if (status.isWrite) nextState = status.othersAny ? ST_INV : ST_GRANT;
        else                nextState = status.needFetch ? ST_FETCH : ST_GRANT;
      end
      ST_INV:     nextState = ST_ACKWAIT;
      ST_ACKWAIT: if (status.pendingEmpty) nextState = ST_GRANT;
      ST_FETCH:   nextState = ST_WBWAIT;
      ST_WBWAIT:  if (wbDone) nextState = ST_GRANT;
      ST_GRANT:   nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    reqReady           = (state == ST_IDLE);
    invValid           = (state == ST_INV);
    fetchValid         = (state == ST_FETCH);
    grantValid         = (state == ST_GRANT);
    strobe.latchReq    = (state == ST_IDLE) && reqValid;
    strobe.loadPending = (state == ST_INV);
    strobe.commit      = (state == ST_GRANT);
  end

  // R9: once a request is taken, the port closes in the next cycle
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R9: the port reopens right after a grant
  p_ready_after_grant_r9: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |=> reqReady);

  // R6: write-back orders are issued only for reads
  p_fetch_only_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> !status.isWrite);

  // R3: invalidate is a single-cycle pulse
  p_inv_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    invValid |=> !invValid);

endmodule

// File: rtl/dircoh_directory.sv
module dircoh_directory
  import dircoh_pkg::*;
#(
  parameter int NUM_PROCS  = 8,
  parameter int NUM_BLOCKS = 64,
  localparam int PROC_W = $clog2(NUM_PROCS),
  localparam int ADDR_W = $clog2(NUM_BLOCKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic                 reqWrite,
  input  logic [PROC_W-1:0]    reqProc,
  input  logic [ADDR_W-1:0]    reqAddr,
  output logic                 invValid,
  output logic [NUM_PROCS-1:0] invMask,
  output logic [ADDR_W-1:0]    invAddr,
  input  logic [NUM_PROCS-1:0] ackIn,
  output logic                 fetchValid,
  output logic [PROC_W-1:0]    fetchOwner,
  output logic [ADDR_W-1:0]    fetchAddr,
  input  logic                 wbDone,
  output logic                 grantValid,
  output logic                 grantWrite,
  output logic [PROC_W-1:0]    grantProc,
  output logic [ADDR_W-1:0]    grantAddr
);

  dirStrobeT            strobe;
  dirStatusT            status;
  logic [NUM_PROCS-1:0] othersMask;
  logic [PROC_W-1:0]    ownerIdx;
  logic                 curWrite;
  logic [PROC_W-1:0]    curProc;
  logic [ADDR_W-1:0]    curAddr;

  dircoh_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .wbDone     (wbDone),
    .status     (status),
    .strobe     (strobe),
    .reqReady   (reqReady),
    .invValid   (invValid),
    .fetchValid (fetchValid),
    .grantValid (grantValid)
  );

  dircoh_datapath #(
    .NUM_PROCS  (NUM_PROCS),
    .NUM_BLOCKS (NUM_BLOCKS)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .status     (status),
    .reqWrite   (reqWrite),
    .reqProc    (reqProc),
    .reqAddr    (reqAddr),
    .ackIn      (ackIn),
    .othersMask (othersMask),
    .ownerIdx   (ownerIdx),
    .curWrite   (curWrite),
    .curProc    (curProc),
    .curAddr    (curAddr)
  );

  assign invMask    = othersMask;
  assign invAddr    = curAddr;
  assign fetchOwner = ownerIdx;
  assign fetchAddr  = curAddr;
  assign grantWrite = curWrite;
  assign grantProc  = curProc;
  assign grantAddr  = curAddr;

  // R3: the invalidate never targets the requester and is never empty
  p_inv_mask_r3: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> (invMask != '0) && !invMask[curProc]);

  // R10: the granted request was latched from the port and held
  p_grant_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> $stable(grantAddr) && $stable(grantProc));

endmodule

// File: tb/dircoh_directory_tb.sv
module dircoh_directory_tb_top;

  localparam int NP = 4;
  localparam int NB = 8;
  localparam int PW = $clog2(NP);
  localparam int AW = $clog2(NB);

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic          rstN;
  logic          reqValid, reqReady, reqWrite;
  logic [PW-1:0] reqProc;
  logic [AW-1:0] reqAddr;
  logic          invValid;
  logic [NP-1:0] invMask;
  logic [AW-1:0] invAddr;
  logic [NP-1:0] ackIn;
  logic          fetchValid;
  logic [PW-1:0] fetchOwner;
  logic [AW-1:0] fetchAddr;
  logic          wbDone;
  logic          grantValid, grantWrite;
  logic [PW-1:0] grantProc;
  logic [AW-1:0] grantAddr;

  dircoh_directory #(.NUM_PROCS(NP), .NUM_BLOCKS(NB)) dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqProc(reqProc), .reqAddr(reqAddr),
    .invValid(invValid), .invMask(invMask), .invAddr(invAddr), .ackIn(ackIn),
    .fetchValid(fetchValid), .fetchOwner(fetchOwner), .fetchAddr(fetchAddr),
    .wbDone(wbDone),
    .grantValid(grantValid), .grantWrite(grantWrite),
    .grantProc(grantProc), .grantAddr(grantAddr)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  int lastAckCyc = 0;
  int lastWbCyc  = 0;

  typedef struct {
    int proc;
    int addr;
    int wr;
    int kind;       // 0 no message, 1 invalidate, 2 write-back
    int acceptCyc;
  } grantItemT;

  grantItemT expGrant[$];
  int expInvMask[$];
  int expInvAddr[$];
  int expOwner[$];
  int expFetchAddr[$];

  // bench-side directory model
  logic [NP-1:0] mPres  [NB];
  logic          mDirty [NB];

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic doReq(int p, int a, int w);
    logic [NP-1:0] bitP;
    logic [NP-1:0] others;
    int kind;
    int acc;
    grantItemT it;
    @(negedge clk);
    reqValid = 1'b1;
    reqWrite = (w != 0);
    reqProc  = PW'(p);
    reqAddr  = AW'(a);
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    acc = cyc;
    reqValid = 1'b0;
    chk("R9", "ready after accept", int'(reqReady), 0);
    bitP = '0;
    bitP[p] = 1'b1;
    others = mPres[a] & ~bitP;
    kind = 0;
    if (w != 0) begin
      if (others != '0) begin
        kind = 1;
        expInvMask.push_back(int'(others));
        expInvAddr.push_back(a);
      end
      mPres[a]  = bitP;
      mDirty[a] = 1'b1;
    end else begin
      if (mDirty[a] && !mPres[a][p]) begin
        kind = 2;
        for (int i = 0; i < NP; i++) if (mPres[a][i]) expOwner.push_back(i);
        expFetchAddr.push_back(a);
        mDirty[a] = 1'b0;
      end
      mPres[a] = mPres[a] | bitP;
    end
    it.proc = p; it.addr = a; it.wr = w; it.kind = kind; it.acceptCyc = acc;
    expGrant.push_back(it);
  endtask

  // invalidate responder: stray ack first, then one real ack per cycle
  initial begin
    logic [NP-1:0] m;
    forever begin
      @(negedge clk);
      if (rstN && invValid) begin
        m = invMask;
        if (expInvMask.size() == 0) chk("R3", "unexpected invalidate", 1, 0);
        else begin
          chk("R3", "invalidate mask", int'(invMask), expInvMask.pop_front());
          chk("R3", "invalidate block", int'(invAddr), expInvAddr.pop_front());
        end
        @(negedge clk);
        chk("R3", "invalidate single pulse", int'(invValid), 0);
        ackIn = ~m;                     // R4: non-target acks must be ignored
        @(negedge clk);
        ackIn = '0;
        for (int i = 0; i < NP; i++) begin
          if (m[i]) begin
            @(negedge clk);
            ackIn = '0;
            ackIn[i] = 1'b1;
            lastAckCyc = cyc;
            @(negedge clk);
            ackIn = '0;
          end
        end
      end
    end
  end

  // write-back responder
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && fetchValid) begin
        if (expOwner.size() == 0) chk("R6", "unexpected write-back order", 1, 0);
        else begin
          chk("R2", "owner index", int'(fetchOwner), expOwner.pop_front());
          chk("R6", "write-back block", int'(fetchAddr), expFetchAddr.pop_front());
        end
        @(negedge clk);
        @(negedge clk);
        wbDone = 1'b1;
        lastWbCyc = cyc;
        @(negedge clk);
        wbDone = 1'b0;
      end
    end
  end

  // grant monitor (scoreboard)
  initial begin
    grantItemT it;
    forever begin
      @(negedge clk);
      if (rstN && grantValid) begin
        if (expGrant.size() == 0) chk("R10", "unexpected grant", 1, 0);
        else begin
          it = expGrant.pop_front();
          chk("R10", "grant processor", int'(grantProc), it.proc);
          chk("R10", "grant block", int'(grantAddr), it.addr);
          chk("R5", "grant exclusive flag", int'(grantWrite), it.wr);
          chk("R9", "ready during grant", int'(reqReady), 0);
          if (it.kind == 0) begin
            if (it.wr != 0) chk("R7", "silent write grant cycle", cyc, it.acceptCyc + 1);
            else            chk("R8", "silent read grant cycle", cyc, it.acceptCyc + 1);
          end else if (it.kind == 1) begin
            chk("R4", "grant after last ack", cyc, lastAckCyc + 2);
          end else begin
            chk("R6", "grant after write-back", cyc, lastWbCyc + 1);
          end
          @(negedge clk);
          chk("R9", "ready after grant", int'(reqReady), 1);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      mPres[b]  = '0;
      mDirty[b] = 1'b0;
    end
    rstN = 1'b0;
    reqValid = 1'b0; reqWrite = 1'b0; reqProc = '0; reqAddr = '0;
    ackIn = '0; wbDone = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", int'(reqReady), 1);
    chk("R1", "grant idle after reset", int'(grantValid), 0);
    chk("R1", "invalidate idle after reset", int'(invValid), 0);
    chk("R1", "write-back idle after reset", int'(fetchValid), 0);

    // R1/R7: first write to an untouched block
    doReq(1, 3, 1);
    // R8: clean reads build a sharer set
    doReq(0, 0, 0);
    doReq(1, 0, 0);
    doReq(2, 0, 0);
    // R3/R4/R5: write with two other sharers
    doReq(1, 0, 1);
    // R6: read of a block dirty elsewhere
    doReq(3, 0, 0);
    // R3/R4: write invalidating the previous owner
    doReq(3, 0, 1);
    // R8: owner re-reads its dirty block
    doReq(3, 0, 0);
    // R7: sole holder writes again
    doReq(3, 0, 1);
    // three sharers then an invalidating write on the last block
    doReq(1, NB - 1, 0);
    doReq(2, NB - 1, 0);
    doReq(3, NB - 1, 0);
    doReq(0, NB - 1, 1);
    // R6: fetch from owner 0, then write over the dirty copy
    doReq(2, NB - 1, 0);
    doReq(1, 3, 0);
    doReq(2, 3, 1);
    // other blocks untouched by the traffic above
    doReq(0, 5, 0);
    doReq(2, 5, 1);

    while (expGrant.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    chk("R3", "invalidates all consumed", expInvMask.size(), 0);
    chk("R6", "write-backs all consumed", expOwner.size(), 0);
    chk("R10", "grants all consumed", expGrant.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule